// File: doc/BRIEF.md
# Memory Error Interrupt Controller

This block gathers error events reported by a memory controller and turns them into a level interrupt for software. Four event classes are tracked: a correctable ECC error, an uncorrectable ECC error, a per-lane parity failure vector and an address error. Each class sets a sticky bit in a status register. An enable register selects which of those bits may drive the interrupt line. A second output flags the pending classes that cannot be recovered.

For each ECC class there is a snapshot record: the failing address and five data words. The record freezes on the first event of its class and re-arms only after software clears that class's status bit. Software uses a single-cycle register port. Reads return one cycle after the request. A write of ones to the status register clears the matching bits.

Top module: `mem_err_irq`

## Requirements
- R1: Status register at word address 0 uses this layout: bit 0 is correctable, bit 1 is uncorrectable, bits 2 to 5 are parity lanes 0 to 3, and bit 6 is address error. An event pulse sets its bit on the next clock edge, and the bit then stays set.
- R2: The enable register sits at word address 1 and uses the status layout. `irq_o` is the OR of (status AND enable), so an enable of zero holds `irq_o` low whatever is pending.
- R3: `fatal_o` is the OR of the enabled uncorrectable, parity and address-error status bits. A correctable error alone never raises `fatal_o`.
- R4: A write to address 0 clears every status bit whose write-data bit is 1. Writing all ones clears all pending status.
- R5: When an event arrives in the same cycle as a clear of its bit, the bit remains set.
- R6: Parity pulses on different lanes accumulate in the status register, one bit per lane.
- R7: The correctable snapshot is read at address 2 (address) and addresses 3 to 7 (data words 0 to 4). It loads on a correctable event while status bit 0 is clear.
- R8: The uncorrectable snapshot is read at address 8 (address) and addresses 9 to 13 (data words 0 to 4). It loads on an uncorrectable event while status bit 1 is clear.
- R9: While its status bit is set, a snapshot ignores later events of its class. After the bit is cleared, the next event loads the snapshot again.
- R10: Writes to snapshot addresses have no effect. Reads of addresses 14 and 15 return zero.
- R11: After reset, status, enable and both snapshots read as zero, and `irq_o` and `fatal_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_evt_i | input | 1 | Correctable error pulse |
| ce_addr_i | input | ADDR_W | Address of correctable error |
| ce_data_i | input | NWORDS*DATA_W | Data words of correctable error, word 0 in the low bits |
| ue_evt_i | input | 1 | Uncorrectable error pulse |
| ue_addr_i | input | ADDR_W | Address of uncorrectable error |
| ue_data_i | input | NWORDS*DATA_W | Data words of uncorrectable error |
| par_evt_i | input | PAR_W | Per-lane parity failure pulses |
| addr_evt_i | input | 1 | Address error pulse |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | Write when high, read when low |
| reg_addr_i | input | RAW | Register word address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| reg_rdata_o | output | DATA_W | Read data |
| irq_o | output | 1 | Summary interrupt |
| fatal_o | output | 1 | Enabled non-recoverable error pending |

## Verification
The bench uses the default parameters: four parity lanes, five data words, and 32-bit address and data. With these values the 14 mapped registers leave two unmapped addresses at the top of the 16-word space, so the zero-read rule can be checked there. Four lanes also allow two separate lanes to be pulsed and their accumulation read back. Snapshot freezing, re-arming and same-cycle set-over-clear are all driven through the register port alone.

// File: rtl/mei_pkg.sv
package mei_pkg;
  localparam int REG_CAUSE   = 0;
  localparam int REG_ENABLE  = 1;
  localparam int REG_CE_BASE = 2;
  localparam int BIT_CE      = 0;
  localparam int BIT_UE      = 1;
  localparam int BIT_PAR     = 2;
  localparam int NUM_REC     = 2;
endpackage

// File: rtl/mei_cause.sv
module mei_cause #(
  parameter int CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] set_i,
  input  logic [CW-1:0] clr_i,
  output logic [CW-1:0] cause_o
);
  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_o <= '0;
    else         cause_o <= (cause_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/mei_capture.sv
module mei_capture #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NWORDS = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     arm_i,
  input  logic                     evt_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [NWORDS*DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0]        addr_o,
  output logic [NWORDS*DATA_W-1:0] data_o
);
  logic load;
  assign load = evt_i & arm_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      data_o <= '0;
    end else if (load) begin
      addr_o <= addr_i;
      data_o <= data_i;
    end
  end
endmodule

// File: rtl/mem_err_irq.sv
module mem_err_irq
  import mei_pkg::*;
#(
  parameter int PAR_W  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int NWORDS = 5,
  parameter int RAW    = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ce_evt_i,
  input  logic [ADDR_W-1:0]        ce_addr_i,
  input  logic [NWORDS*DATA_W-1:0] ce_data_i,
  input  logic                     ue_evt_i,
  input  logic [ADDR_W-1:0]        ue_addr_i,
  input  logic [NWORDS*DATA_W-1:0] ue_data_i,
  input  logic [PAR_W-1:0]         par_evt_i,
  input  logic                     addr_evt_i,
  input  logic                     reg_req_i,
  input  logic                     reg_we_i,
  input  logic [RAW-1:0]           reg_addr_i,
  input  logic [DATA_W-1:0]        reg_wdata_i,
  output logic                     reg_rvalid_o,
  output logic [DATA_W-1:0]        reg_rdata_o,
  output logic                     irq_o,
  output logic                     fatal_o
);
  localparam int CW       = PAR_W + 3;
  localparam int ADDR_BIT = BIT_PAR + PAR_W;
  localparam int REC_SPAN = NWORDS + 1;
  localparam logic [CW-1:0] FATAL_M = {1'b1, {PAR_W{1'b1}}, 1'b1, 1'b0};

  logic [CW-1:0] cause_q, enable_q, set_vec, clr_vec;
  logic          wr_cause, wr_enable;

  assign wr_cause  = reg_req_i & reg_we_i & (reg_addr_i == RAW'(REG_CAUSE));
  assign wr_enable = reg_req_i & reg_we_i & (reg_addr_i == RAW'(REG_ENABLE));
  assign set_vec   = {addr_evt_i, par_evt_i, ue_evt_i, ce_evt_i};
  assign clr_vec   = wr_cause ? reg_wdata_i[CW-1:0] : '0;

  mei_cause #(.CW(CW)) u_cause (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .cause_o(cause_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        enable_q <= '0;
    else if (wr_enable) enable_q <= reg_wdata_i[CW-1:0];
  end

  assign irq_o   = |(cause_q & enable_q);
  assign fatal_o = |(cause_q & enable_q & FATAL_M);

  // snapshot records: index 0 correctable, 1 uncorrectable
  logic [NUM_REC-1:0]                    cap_evt;
  logic [NUM_REC-1:0][ADDR_W-1:0]        cap_addr_in, cap_addr;
  logic [NUM_REC-1:0][NWORDS*DATA_W-1:0] cap_data_in, cap_data;

  assign cap_evt     = {ue_evt_i, ce_evt_i};
  assign cap_addr_in = {ue_addr_i, ce_addr_i};
  assign cap_data_in = {ue_data_i, ce_data_i};

  for (genvar g = 0; g < NUM_REC; g++) begin : g_rec
    mei_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NWORDS(NWORDS)) u_cap (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .arm_i (~cause_q[BIT_CE + g]),
      .evt_i (cap_evt[g]),
      .addr_i(cap_addr_in[g]),
      .data_i(cap_data_in[g]),
      .addr_o(cap_addr[g]),
      .data_o(cap_data[g])
    );
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (int'(reg_addr_i) == REG_CAUSE)  rd_mux[CW-1:0] = cause_q;
    if (int'(reg_addr_i) == REG_ENABLE) rd_mux[CW-1:0] = enable_q;
    for (int r = 0; r < NUM_REC; r++) begin
      if (int'(reg_addr_i) == REG_CE_BASE + r*REC_SPAN)
        rd_mux = DATA_W'(cap_addr[r]);
      for (int w = 0; w < NWORDS; w++) begin
        if (int'(reg_addr_i) == REG_CE_BASE + r*REC_SPAN + 1 + w)
          rd_mux = cap_data[r][w*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_rvalid_o <= 1'b0;
      reg_rdata_o  <= '0;
    end else begin
      reg_rvalid_o <= reg_req_i & ~reg_we_i;
      if (reg_req_i & ~reg_we_i) reg_rdata_o <= rd_mux;
    end
  end
endmodule

// File: rtl/mei_checker.sv
module mei_checker #(
  parameter int PAR_W  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int RAW    = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_evt_i,
  input logic              addr_evt_i,
  input logic              reg_req_i,
  input logic              reg_we_i,
  input logic [RAW-1:0]    reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [PAR_W+2:0]  cause_i,
  input logic [PAR_W+2:0]  enable_i,
  input logic [ADDR_W-1:0] ce_cap_i,
  input logic              irq_o,
  input logic              fatal_o
);
  localparam int AB = PAR_W + 2;
  logic wr_c;
  assign wr_c = reg_req_i & reg_we_i & (reg_addr_i == '0);

  a_r1_ce_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_evt_i |=> cause_i[0]);
  a_r2_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i == '0) |-> !irq_o);
  a_r3_fatal_in_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |-> irq_o);
  a_r3_ce_not_fatal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_i == {{(AB){1'b0}}, 1'b1}) |-> !fatal_o);
  a_r4_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_c && reg_wdata_i[0] && !ce_evt_i) |=> !cause_i[0]);
  a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_c && reg_wdata_i[AB] && addr_evt_i) |=> cause_i[AB]);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_i[0] && ce_evt_i) |=> $stable(ce_cap_i));
endmodule

bind mem_err_irq mei_checker #(
  .PAR_W(PAR_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RAW(RAW)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ce_evt_i   (ce_evt_i),
  .addr_evt_i (addr_evt_i),
  .reg_req_i  (reg_req_i),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .cause_i    (cause_q),
  .enable_i   (enable_q),
  .ce_cap_i   (cap_addr[0]),
  .irq_o      (irq_o),
  .fatal_o    (fatal_o)
);

// File: tb/sim_mem_err_irq.sv
module sim_mem_err_irq;
  localparam int PW = 4, DW = 32, AW = 32, NW = 5, RAW = 4;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic           ce_evt = 0, ue_evt = 0, addr_evt = 0;
  logic [AW-1:0]  ce_addr = 0, ue_addr = 0;
  logic [NW*DW-1:0] ce_data = 0, ue_data = 0;
  logic [PW-1:0]  par_evt = 0;
  logic           req = 0, we = 0;
  logic [RAW-1:0] addr = 0;
  logic [DW-1:0]  wdata = 0;
  logic           rvalid, irq, fatal;
  logic [DW-1:0]  rdata;

  mem_err_irq #(.PAR_W(PW), .DATA_W(DW), .ADDR_W(AW), .NWORDS(NW), .RAW(RAW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ce_evt_i(ce_evt), .ce_addr_i(ce_addr), .ce_data_i(ce_data),
    .ue_evt_i(ue_evt), .ue_addr_i(ue_addr), .ue_data_i(ue_data),
    .par_evt_i(par_evt), .addr_evt_i(addr_evt),
    .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rvalid_o(rvalid), .reg_rdata_o(rdata), .irq_o(irq), .fatal_o(fatal));

  int n_cmp = 0, n_bad = 0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  bit            done = 0;

  task automatic cmp(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rvalid) begin
      if (exp_q.size() == 0) cmp(rdata, 32'hxxxx_xxxx, "unexpected read");
      else cmp(rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic rd(input int a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk); req = 1; we = 0; addr = RAW'(a);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); req = 0;
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk); req = 1; we = 1; addr = RAW'(a); wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic pins(input logic ei, input logic ef, input string tag);
    @(negedge clk);
    cmp({31'd0, irq}, {31'd0, ei}, {tag, " irq"});
    cmp({31'd0, fatal}, {31'd0, ef}, {tag, " fatal"});
  endtask

  function automatic logic [NW*DW-1:0] mk(input logic [DW-1:0] base);
    logic [NW*DW-1:0] v;
    for (int w = 0; w < NW; w++) v[w*DW +: DW] = base + DW'(w);
    return v;
  endfunction

  task automatic pulse_ce(input logic [AW-1:0] a, input logic [DW-1:0] b);
    @(negedge clk); ce_evt = 1; ce_addr = a; ce_data = mk(b);
    @(negedge clk); ce_evt = 0;
  endtask

  task automatic pulse_ue(input logic [AW-1:0] a, input logic [DW-1:0] b);
    @(negedge clk); ue_evt = 1; ue_addr = a; ue_data = mk(b);
    @(negedge clk); ue_evt = 0;
  endtask

  task automatic pulse_par(input logic [PW-1:0] p);
    @(negedge clk); par_evt = p;
    @(negedge clk); par_evt = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state, R10 unmapped addresses
    for (int a = 0; a < 14; a++) rd(a, 0, "R11 reset reg");
    rd(14, 0, "R10 unmapped 14");
    rd(15, 0, "R10 unmapped 15");
    pins(0, 0, "R11 reset");

    wr(1, 32'h7F);
    rd(1, 32'h7F, "R2 enable readback");

    pulse_ce(32'h100, 32'hC0DE_0000);
    rd(0, 32'h01, "R1 ce status");
    pins(1, 0, "R3 ce not fatal");
    rd(2, 32'h100, "R7 ce addr");
    for (int w = 0; w < NW; w++) rd(3 + w, 32'hC0DE_0000 + w, "R7 ce data");

    pulse_ce(32'h200, 32'hBAD0_0000);
    rd(2, 32'h100, "R9 ce addr held");
    rd(3, 32'hC0DE_0000, "R9 ce data held");

    wr(0, 32'h01);
    rd(0, 0, "R4 w1c ce");
    pins(0, 0, "R4 cleared");
    pulse_ce(32'h300, 32'h1234_0000);
    rd(2, 32'h300, "R9 rearm addr");
    rd(7, 32'h1234_0004, "R9 rearm data4");

    pulse_ue(32'h400, 32'hDEAD_0000);
    pins(1, 1, "R3 ue fatal");
    rd(0, 32'h03, "R1 ue status");
    rd(8, 32'h400, "R8 ue addr");
    for (int w = 0; w < NW; w++) rd(9 + w, 32'hDEAD_0000 + w, "R8 ue data");

    wr(0, 32'hFFFF_FFFF);
    rd(0, 0, "R4 clear all");
    pins(0, 0, "R4 all clear");

    wr(1, 0);
    pulse_par(4'b0001);
    pulse_par(4'b0100);
    rd(0, 32'h14, "R6 parity lanes");
    pins(0, 0, "R2 masked");
    wr(1, 32'h3C);
    pins(1, 1, "R3 parity fatal");

    wr(1, 32'h7F);
    wr(0, 32'h7F);
    @(negedge clk); req = 1; we = 1; addr = 0; wdata = 32'h40; addr_evt = 1;
    @(negedge clk); req = 0; we = 0; addr_evt = 0;
    rd(0, 32'h40, "R5 set wins");
    pins(1, 1, "R3 addr fatal");

    wr(2, 32'hFFFF_FFFF);
    rd(2, 32'h300, "R10 ce addr write ignored");
    wr(9, 32'hFFFF_FFFF);
    rd(9, 32'hDEAD_0000, "R10 ue data write ignored");

    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk);
    done = 1;
    summary();
  end
endmodule